// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Controller

This block collects condition lines from a baseband datapath and turns them into two active-low interrupt request pins. The conditions fall into three groups: transmit FIFO level conditions, arithmetic overflow events from the filters and the gain, phase and offset stages of both directions, and over-amplitude events on the receive converter's I and Q channels. Each group has its own sticky status register. Software finds the cause by reading a status register, and that read also clears the bits whose condition has already gone.

A bit whose condition is still present when its register is read stays set. Its request therefore stays asserted until software has removed the cause (for example by refilling the FIFO, or once the input amplitude has fallen) and then read the register one more time. A routing register enables each group and picks which of the two pins it drives. Register access is through a simple synchronous port. Read data appears one cycle after the read strobe, and a read's clearing effect takes place on the strobe cycle.

Top module: `rc_irq_ctrl`

## Requirements
- R1: After reset all status bits, the route register and the read data are zero, and both `irq_n` pins are high.
- R2: A condition line that is high in a cycle sets its status bit at that clock edge. The bit stays set after the line falls, for as long as no read of its register clears it.
- R3: A read strobe at address 0 (FIFO group), 1 (arithmetic group), 2 (converter group) or 3 (route register) puts that register's value, as held in the strobe cycle, on `bus_rdata` after the next edge. Status bits are zero-extended to 8 bits.
- R4: A read of a status register clears each of its bits whose condition line is low in the strobe cycle.
- R5: A bit whose condition line is high in the strobe cycle of a read of its register is still set after the read. This covers both a held level and a new event arriving in that cycle.
- R6: A read of one address leaves the status bits of the other groups unchanged.
- R7: A write strobe at address 3 loads the route register. Bits 2:0 are the enables for groups 0, 1 and 2. Bits 6:4 are the pin selects for groups 0, 1 and 2, where 0 selects `irq_n[0]` and 1 selects `irq_n[1]`. Bits 3 and 7 are always read back as zero.
- R8: `irq_n[p]` is low exactly when some enabled group whose select equals p has at least one status bit set.
- R9: A disabled group never pulls a pin low, but its status bits still set and can be read.
- R10: A write to addresses 0 to 2 changes no status bit and leaves the route register unchanged.
- R11: In a cycle with no read strobe, `bus_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_fifo | input | FIFO_W (2) | Transmit FIFO level condition lines |
| cond_arith | input | ARITH_W (8) | Filter and gain/phase/offset overflow condition lines |
| cond_adc | input | ADC_W (2) | Converter I/Q over-amplitude condition lines |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the read strobe |
| irq_n | output | 2 | Active-low interrupt request pins |

## Verification
The assertions assume that the condition lines are synchronous to `clk`, and that a read strobe and a write strobe never occur in the same cycle. The sticky, clear and priority properties are stated per bit, relative to the read decode of that bit's own group. The bench drives at most one strobe per cycle and changes every input one nanosecond after a rising edge. Condition lines are held as levels or pulsed for single cycles, some of them placed exactly on the strobe cycle of a clearing read.

// File: rtl/rc_irq_pkg.sv
package rc_irq_pkg;
  localparam int REG_W      = 8;
  localparam int NGRP       = 3;
  localparam int ADDR_W     = 2;
  localparam int ROUTE_ADDR = 3;
  localparam int SEL_LSB    = 4;
  localparam logic [REG_W-1:0] ROUTE_MASK = 8'h77;

  // next value of one sticky bit: an event wins over a clearing read
  function automatic logic f_sticky(input logic cond, input logic cur, input logic clr);
    return cond | (cur & ~clr);
  endfunction

  // groups of the route register that feed pin 'pin'
  function automatic logic [NGRP-1:0] f_pin_groups(input logic [REG_W-1:0] route,
                                                   input logic pin);
    logic [NGRP-1:0] m;
    for (int g = 0; g < NGRP; g++)
      m[g] = route[g] & (route[SEL_LSB+g] == pin);
    return m;
  endfunction
endpackage

// File: rtl/rc_irq_group.sv
module rc_irq_group #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         rd_hit,
  output logic [W-1:0] stat,
  output logic         any_set
);
  import rc_irq_pkg::*;

  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= f_sticky(cond[i], stat_q[i], rd_hit);
    end

    // R2: an event always lands in the status bit
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cond[i] |=> stat_q[i]);
    // R5: a bit is kept without a read or while its condition holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && (!rd_hit || cond[i])) |=> stat_q[i]);
    // R4: a read with the condition gone clears the bit
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !cond[i]) |=> !stat_q[i]);
  end

  assign stat    = stat_q;
  assign any_set = |stat_q;
endmodule

// File: rtl/rc_irq_route.sv
module rc_irq_route (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_hit,
  input  logic [rc_irq_pkg::REG_W-1:0]  wdata,
  input  logic [rc_irq_pkg::NGRP-1:0]   grp_any,
  output logic [rc_irq_pkg::REG_W-1:0]  route,
  output logic [1:0]                    irq_n
);
  import rc_irq_pkg::*;

  logic [REG_W-1:0] route_q;
  logic [NGRP-1:0]  feed0, feed1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      route_q <= '0;
    else if (wr_hit) route_q <= wdata & ROUTE_MASK;
  end

  assign feed0 = f_pin_groups(route_q, 1'b0) & grp_any;
  assign feed1 = f_pin_groups(route_q, 1'b1) & grp_any;
  assign irq_n = ~{|feed1, |feed0};
  assign route = route_q;

  // R10: route register only moves on its own write
  p_route_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(route_q));
  // R9: with every group disabled both pins are idle
  p_idle_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q[NGRP-1:0] == '0) |-> (irq_n == 2'b11));
  // R7: reserved route bits never become set
  p_resv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q & ~ROUTE_MASK) == '0);
endmodule

// File: rtl/rc_irq_rdport.sv
module rc_irq_rdport (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd,
  input  logic [rc_irq_pkg::ADDR_W-1:0] addr,
  input  logic [rc_irq_pkg::REG_W-1:0]  reg0,
  input  logic [rc_irq_pkg::REG_W-1:0]  reg1,
  input  logic [rc_irq_pkg::REG_W-1:0]  reg2,
  input  logic [rc_irq_pkg::REG_W-1:0]  reg3,
  output logic [rc_irq_pkg::REG_W-1:0]  rdata
);
  import rc_irq_pkg::*;

  logic [REG_W-1:0] sel_d, rdata_q;

  always_comb begin
    unique case (addr)
      2'd0:    sel_d = reg0;
      2'd1:    sel_d = reg1;
      2'd2:    sel_d = reg2;
      default: sel_d = reg3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= sel_d;
  end

  assign rdata = rdata_q;

  // R11: read data holds between reads
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q));
endmodule

// File: rtl/rc_irq_ctrl.sv
module rc_irq_ctrl #(
  parameter int FIFO_W  = 2,
  parameter int ARITH_W = 8,
  parameter int ADC_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [FIFO_W-1:0]            cond_fifo,
  input  logic [ARITH_W-1:0]           cond_arith,
  input  logic [ADC_W-1:0]             cond_adc,
  input  logic [rc_irq_pkg::ADDR_W-1:0] bus_addr,
  input  logic                         bus_rd,
  input  logic                         bus_wr,
  input  logic [rc_irq_pkg::REG_W-1:0] bus_wdata,
  output logic [rc_irq_pkg::REG_W-1:0] bus_rdata,
  output logic [1:0]                   irq_n
);
  import rc_irq_pkg::*;

  logic [NGRP-1:0]   rd_hit;
  logic [NGRP-1:0]   grp_any;
  logic              route_wr;
  logic [FIFO_W-1:0] st_fifo;
  logic [ARITH_W-1:0] st_arith;
  logic [ADC_W-1:0]  st_adc;
  logic [REG_W-1:0]  x_fifo, x_arith, x_adc, route;

  for (genvar g = 0; g < NGRP; g++) begin : g_dec
    assign rd_hit[g] = bus_rd && (bus_addr == ADDR_W'(g));
  end
  assign route_wr = bus_wr && (bus_addr == ADDR_W'(ROUTE_ADDR));

  rc_irq_group #(.W(FIFO_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .cond(cond_fifo), .rd_hit(rd_hit[0]),
    .stat(st_fifo), .any_set(grp_any[0]));
  rc_irq_group #(.W(ARITH_W)) u_arith (
    .clk(clk), .rst_n(rst_n), .cond(cond_arith), .rd_hit(rd_hit[1]),
    .stat(st_arith), .any_set(grp_any[1]));
  rc_irq_group #(.W(ADC_W)) u_adc (
    .clk(clk), .rst_n(rst_n), .cond(cond_adc), .rd_hit(rd_hit[2]),
    .stat(st_adc), .any_set(grp_any[2]));

  always_comb begin
    x_fifo  = '0; x_fifo[FIFO_W-1:0]   = st_fifo;
    x_arith = '0; x_arith[ARITH_W-1:0] = st_arith;
    x_adc   = '0; x_adc[ADC_W-1:0]     = st_adc;
  end

  rc_irq_route u_route (
    .clk(clk), .rst_n(rst_n), .wr_hit(route_wr), .wdata(bus_wdata),
    .grp_any(grp_any), .route(route), .irq_n(irq_n));

  rc_irq_rdport u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .reg0(x_fifo), .reg1(x_arith), .reg2(x_adc), .reg3(route),
    .rdata(bus_rdata));

  // R3: input rule relied upon by the port checks
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  // R6: a read of group 0 leaves the converter group unchanged when it has no event
  p_other_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit[2] && cond_adc == '0) |=> $stable(st_adc));
endmodule

// File: tb/rc_irq_ctrl_bench.sv
`timescale 1ns/1ps
module rc_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cond_fifo = '0;
  logic [7:0] cond_arith = '0;
  logic [1:0] cond_adc = '0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] irq_n;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_stat[3];
  int m_route, m_rdata, m_irq;

  always #10 clk = ~clk;

  rc_irq_ctrl u_rc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cond_fifo(cond_fifo), .cond_arith(cond_arith),
    .cond_adc(cond_adc), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n));

  task automatic chk(input int act, input int exp, input string req, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pins_of(input int route, input int st0, input int st1, input int st2);
    int st[3];
    int p;
    st[0] = st0; st[1] = st1; st[2] = st2;
    p = 3;
    for (int g = 0; g < 3; g++)
      if (((route >> g) & 1) && st[g] != 0) begin
        if ((route >> (4 + g)) & 1) p &= ~2; else p &= ~1;
      end
    return p;
  endfunction

  task automatic step();
    int cond[3];
    int nst[3];
    cond[0] = int'(cond_fifo); cond[1] = int'(cond_arith); cond[2] = int'(cond_adc);
    if (bus_rd) m_rdata = (bus_addr == 3) ? m_route : m_stat[bus_addr];
    for (int g = 0; g < 3; g++) begin
      nst[g] = m_stat[g];
      if (bus_rd && bus_addr == g) nst[g] = 0;
      nst[g] |= cond[g];
    end
    if (bus_wr && bus_addr == 3) m_route = int'(bus_wdata) & 'h77;
    @(posedge clk); #1;
    for (int g = 0; g < 3; g++) m_stat[g] = nst[g];
    m_irq = pins_of(m_route, m_stat[0], m_stat[1], m_stat[2]);
    chk(int'(bus_rdata), m_rdata, cur_req, "rdata");
    chk(int'(irq_n), m_irq, cur_req, "irq_n");
  endtask

  task automatic rd(input int a);
    bus_addr = 2'(a); bus_rd = 1'b1; step(); bus_rd = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 2'(a); bus_wdata = 8'(d); bus_wr = 1'b1; step(); bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 3; g++) m_stat[g] = 0;
    m_route = 0; m_rdata = 0; m_irq = 3;
    repeat (3) @(posedge clk);
    #1;
    chk(int'(bus_rdata), 0, "R1", "rdata in reset");
    chk(int'(irq_n), 3, "R1", "irq_n in reset");
    rst_n = 1'b1;
    cur_req = "R1";
    idle(2);
    rd(0); rd(1); rd(2); rd(3);
    chk(int'(bus_rdata), 0, "R1", "route after reset");

    // R2: single-cycle FIFO pulse is held
    cur_req = "R2";
    cond_fifo = 2'b01; step(); cond_fifo = 2'b00;
    idle(3);
    // R3 / R4: read returns it, then clears
    cur_req = "R3"; rd(0);
    chk(int'(bus_rdata), 1, "R3", "fifo read value");
    cur_req = "R4"; rd(0);
    chk(int'(bus_rdata), 0, "R4", "fifo cleared");

    // R5: held converter level survives reads
    cur_req = "R5";
    cond_adc = 2'b11; step();
    rd(2); rd(2);
    chk(int'(bus_rdata), 3, "R5", "adc held level");
    cond_adc = 2'b00; step();
    rd(2);
    chk(int'(bus_rdata), 3, "R5", "adc last set read");
    rd(2);
    chk(int'(bus_rdata), 0, "R4", "adc cleared after level drop");

    // R5: event in the read cycle wins
    cond_arith = 8'h10; step(); cond_arith = 8'h00;
    bus_addr = 2'd1; bus_rd = 1'b1; cond_arith = 8'h80; step();
    bus_rd = 1'b0; cond_arith = 8'h00;
    chk(int'(bus_rdata), 'h10, "R5", "arith read value");
    rd(1);
    chk(int'(bus_rdata), 'h80, "R5", "same-cycle event kept");

    // R6: read of another group leaves this one alone
    cur_req = "R6";
    cond_arith = 8'h05; step(); cond_arith = 8'h00;
    rd(0); rd(2);
    rd(1);
    chk(int'(bus_rdata), 'h05, "R6", "arith kept across other reads");

    // R7: route register readback masking
    cur_req = "R7";
    wr(3, 'hFF); rd(3);
    chk(int'(bus_rdata), 'h77, "R7", "route readback");

    // R8: converter group to pin 1, FIFO group to pin 0
    cur_req = "R8";
    wr(3, 'h45);
    cond_adc = 2'b10; step(); cond_adc = 2'b00;
    chk(int'(irq_n), 2'b01, "R8", "adc on pin1");
    cond_fifo = 2'b10; step(); cond_fifo = 2'b00;
    chk(int'(irq_n), 2'b00, "R8", "both pins low");
    rd(2);
    chk(int'(irq_n), 2'b10, "R8", "pin1 released after read");
    rd(0);
    chk(int'(irq_n), 2'b11, "R8", "pin0 released after read");

    // R9: disabled arithmetic group still records but no pin
    cur_req = "R9";
    cond_arith = 8'h22; step(); cond_arith = 8'h00;
    chk(int'(irq_n), 2'b11, "R9", "disabled group pin");
    rd(1);
    chk(int'(bus_rdata), 'h22, "R9", "disabled group status");

    // R10: writes to status addresses ignored
    cur_req = "R10";
    cond_fifo = 2'b01; step(); cond_fifo = 2'b00;
    wr(0, 'h00); wr(1, 'hFF); wr(2, 'hFF);
    rd(0);
    chk(int'(bus_rdata), 1, "R10", "fifo after write");
    rd(2);
    chk(int'(bus_rdata), 0, "R10", "adc after write");
    rd(3);
    chk(int'(bus_rdata), 'h45, "R10", "route after status writes");

    // R11: read data holds without a strobe
    cur_req = "R11";
    cond_adc = 2'b01; idle(3); cond_adc = 2'b00;
    chk(int'(bus_rdata), 'h45, "R11", "rdata held");
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule